// File: doc/BRIEF.md
# Interval timer host register and latch interface

This block is the byte-wide register front end of a multi-channel interval timer. A host writes control words and count bytes through four addresses: one data port per channel at addresses 0 to NUM_CH-1 and a single control port at address 3. The block turns control words into a per-channel configuration: counting mode, access mode and decimal flag. It turns byte writes into 16-bit load strobes for the counting core. It serves reads from the live count, from a frozen count snapshot, or from a captured status byte.

The counting core is outside this block. The core supplies each channel's live 16-bit count and output level. It consumes the load strobe, the 16-bit load value, the mode and the decimal flag. Read data is combinational: `rdata` reflects the addressed channel during the cycle in which `rd_en` is high. The read side effects, such as toggles advancing and latches being released, take place at the clock edge that ends that cycle. A load strobe is high for the one cycle that follows the write that completes a count.

Top module: `tmr_host_if`

## Requirements
- R1: A write to address 3 with bits 7:6 below 3 addresses channel 0, 1 or 2. If access bits 5:4 are non-zero, that channel alone takes the access mode from bits 5:4, the counting mode from bits 3:1 and the decimal flag from bit 0. These values appear on `mode_o` and `bcd_o` after the edge. The other channels keep their settings.
- R2: Counting-mode codes 6 and 7 are stored and reported as 2 and 3.
- R3: A control word with access bits equal to 0 freezes the addressed channel's live count as a snapshot. It leaves that channel's mode, access mode and decimal flag unchanged.
- R4: In access mode 1 (low byte only), each data write loads {8'h00, byte}. `ld_stb` for that channel is high during the cycle after the write.
- R5: In access mode 2 (high byte only), each data write loads {byte, 8'h00}.
- R6: In access mode 3 (word), the first data write is held and produces no strobe. The second write loads {second, first}.
- R7: Live reads return the low byte in access mode 1 and the high byte in mode 2. In mode 3 they return the low byte and the high byte alternately, starting with the low byte.
- R8: Any configuring control word resets that channel's read and write byte toggles to the low byte.
- R9: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2, and several channels may be selected at once. Bit 5 low requests a count snapshot and bit 4 low requests a status capture.
- R10: A captured status byte holds the output level in bit 7, 0 in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and the decimal flag in bit 0. These are the values at the time of the command.
- R11: A count snapshot request is ignored while an earlier snapshot of that channel is still unread. A status request is ignored while an earlier status byte of that channel is still unread.
- R12: A data read returns a pending status byte first, then a pending count snapshot, then the live count. Reads of the status byte and of the snapshot do not advance the live read toggle.
- R13: A snapshot taken in word mode reads back as the low byte and then the high byte, and is released after the high byte. In modes 1 and 2 the snapshot is released after its single byte.
- R14: After reset every channel is in access mode 1, counting mode 0 and decimal flag 0. No snapshot or status byte is pending, no strobe is active and the toggles point at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write this cycle |
| rd_en | input | 1 | Host byte read this cycle |
| addr | input | 2 | Port select: channel data 0..NUM_CH-1, control 3 |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the addressed channel (0 at address 3) |
| live_cnt | input | NUM_CH*16 | Current count of each channel, channel 0 in the low bits |
| live_out | input | NUM_CH | Current output level of each channel |
| ld_stb | output | NUM_CH | One-cycle load strobe per channel |
| ld_val | output | NUM_CH*16 | Assembled load value per channel |
| mode_o | output | NUM_CH*3 | Stored counting mode per channel (0..5) |
| bcd_o | output | NUM_CH | Stored decimal flag per channel |

## Verification
The bench builds the block with the default NUM_CH of 3. This puts every read-back selection bit within reach, including a command that selects two channels at once. It also lets the three access modes be configured side by side on separate channels. Because the live counts are bench-driven inputs, the bench changes them between a snapshot and its read. This separates snapshot data from live data, exposes the priority order of status, snapshot and live reads, and shows that a repeated request is ignored.

// File: rtl/tmr_pkg.sv
// Shared encodings for the timer host interface.
// Assumes byte-wide host access and 16-bit channel counts.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    // Access field of a control word; ACC_LATCH doubles as "nothing pending".
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    localparam logic [1:0] SEL_READBACK = 2'd3;
    localparam logic [1:0] CTRL_ADDR    = 2'd3;
endpackage

// File: rtl/tmr_ctl_decode.sv
// Control-port and data-port write decoder.
// Turns one host write into per-channel request pulses. Purely combinational.
// Assumes NUM_CH is 1..3, because the read-back select bits cover three channels.
module tmr_ctl_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [NUM_CH-1:0]   cfg_wr,
    output logic [NUM_CH-1:0]   cnt_lat_req,
    output logic [NUM_CH-1:0]   st_lat_req,
    output logic [NUM_CH-1:0]   data_wr,
    output acc_e                new_acc,
    output logic [MODE_W-1:0]   new_mode,
    output logic                new_bcd
);
    logic       ctl_hit;
    logic [1:0] sel;
    logic       is_rb;

    // Field extraction shared by all channels
    always_comb begin
        ctl_hit  = wr_en && (addr == CTRL_ADDR);
        sel      = wdata[7:6];
        is_rb    = (sel == SEL_READBACK);
        new_acc  = acc_e'(wdata[5:4]);
        new_bcd  = wdata[0];
        // Codes 6 and 7 alias onto 2 and 3
        new_mode = (wdata[3] && wdata[2]) ? {1'b0, wdata[2:1]} : wdata[3:1];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic picked;
        logic rb_pick;
        // Per-channel request generation
        always_comb begin
            picked         = ctl_hit && !is_rb && (sel == 2'(i));
            rb_pick        = ctl_hit && is_rb && wdata[i+1];
            cfg_wr[i]      = picked && (new_acc != ACC_LATCH);
            cnt_lat_req[i] = (picked && (new_acc == ACC_LATCH)) || (rb_pick && !wdata[5]);
            st_lat_req[i]  = rb_pick && !wdata[4];
            data_wr[i]     = wr_en && (addr == 2'(i));
        end
    end
endmodule

// File: rtl/tmr_chan_regs.sv
// One channel's host-side state.
// Holds the configuration, the byte toggles, the write hold byte, the count
// snapshot, the status capture and the load strobe.
// Assumes the requests from the decoder are mutually exclusive per cycle.
module tmr_chan_regs
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  acc_e                new_acc,
    input  logic [MODE_W-1:0]   new_mode,
    input  logic                new_bcd,
    input  logic                cnt_lat_req,
    input  logic                st_lat_req,
    input  logic                data_wr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                rd_sel,
    input  logic [CNT_W-1:0]    live_cnt,
    input  logic                live_out,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                ld_stb,
    output logic [CNT_W-1:0]    ld_val,
    output logic [MODE_W-1:0]   mode_q,
    output logic                bcd_q
);
    acc_e              acc_q;
    logic              wr_hi, rd_hi;
    logic [BYTE_W-1:0] wr_hold;
    acc_e              cl_pend;
    logic [CNT_W-1:0]  cl_val;
    logic              st_pend;
    logic [BYTE_W-1:0] st_val;

    // Channel state update: reads, configuration, data writes, latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_LO;
            mode_q  <= '0;
            bcd_q   <= 1'b0;
            wr_hi   <= 1'b0;
            rd_hi   <= 1'b0;
            wr_hold <= '0;
            cl_pend <= ACC_LATCH;
            cl_val  <= '0;
            st_pend <= 1'b0;
            st_val  <= '0;
            ld_stb  <= 1'b0;
            ld_val  <= '0;
        end else begin
            ld_stb <= 1'b0;
            if (rd_sel) begin
                if (st_pend) begin
                    st_pend <= 1'b0;
                end else if (cl_pend != ACC_LATCH) begin
                    cl_pend <= (cl_pend == ACC_WORD) ? ACC_HI : ACC_LATCH;
                end else if (acc_q == ACC_WORD) begin
                    rd_hi <= !rd_hi;
                end
            end
            if (cfg_wr) begin
                acc_q  <= new_acc;
                mode_q <= new_mode;
                bcd_q  <= new_bcd;
                wr_hi  <= 1'b0;
                rd_hi  <= 1'b0;
            end else if (data_wr) begin
                case (acc_q)
                    ACC_LO: begin
                        ld_stb <= 1'b1;
                        ld_val <= {{BYTE_W{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        ld_stb <= 1'b1;
                        ld_val <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!wr_hi) begin
                            wr_hold <= wdata;
                            wr_hi   <= 1'b1;
                        end else begin
                            ld_stb <= 1'b1;
                            ld_val <= {wdata, wr_hold};
                            wr_hi  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (cnt_lat_req && (cl_pend == ACC_LATCH)) begin
                cl_val  <= live_cnt;
                cl_pend <= acc_q;
            end
            if (st_lat_req && !st_pend) begin
                st_val  <= {live_out, 1'b0, acc_q, mode_q, bcd_q};
                st_pend <= 1'b1;
            end
        end
    end

    // Read byte selection: status, then snapshot, then live count
    always_comb begin
        if (st_pend) begin
            rd_byte = st_val;
        end else begin
            case (cl_pend)
                ACC_LO, ACC_WORD: rd_byte = cl_val[BYTE_W-1:0];
                ACC_HI:           rd_byte = cl_val[CNT_W-1:BYTE_W];
                default: begin
                    if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi))
                        rd_byte = live_cnt[CNT_W-1:BYTE_W];
                    else
                        rd_byte = live_cnt[BYTE_W-1:0];
                end
            endcase
        end
    end

    AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> $past(data_wr));                                          // R4
    AST_WORD_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !cfg_wr && acc_q == ACC_WORD && !wr_hi) |=> !ld_stb);    // R6
    AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q <= 3'd5);                                                     // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(mode_q) && $stable(bcd_q)));                    // R3
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_pend != ACC_LATCH) |=> $stable(cl_val));                         // R11
    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && st_pend && !cnt_lat_req) |=> $stable(cl_pend));           // R12
endmodule

// File: rtl/tmr_host_if.sv
// Top of the timer host register interface.
// Decodes host writes, keeps one register set per channel and multiplexes
// the read byte by address. Read data is combinational from rd_en and addr.
// Assumes NUM_CH is 1..3 and at most one of wr_en and rd_en per cycle for the
// same channel.
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic [NUM_CH*16-1:0]     live_cnt,
    input  logic [NUM_CH-1:0]        live_out,
    output logic [NUM_CH-1:0]        ld_stb,
    output logic [NUM_CH*16-1:0]     ld_val,
    output logic [NUM_CH*3-1:0]      mode_o,
    output logic [NUM_CH-1:0]        bcd_o
);
    logic [NUM_CH-1:0]             cfg_wr, cnt_lat_req, st_lat_req, data_wr, rd_sel;
    acc_e                          new_acc;
    logic [MODE_W-1:0]             new_mode;
    logic                          new_bcd;
    logic [NUM_CH-1:0][BYTE_W-1:0] rd_byte_a;

    tmr_ctl_decode #(.NUM_CH(NUM_CH)) i_dec (
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .cfg_wr      (cfg_wr),
        .cnt_lat_req (cnt_lat_req),
        .st_lat_req  (st_lat_req),
        .data_wr     (data_wr),
        .new_acc     (new_acc),
        .new_mode    (new_mode),
        .new_bcd     (new_bcd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Read select for this channel's data port
        always_comb rd_sel[i] = rd_en && (addr == 2'(i));

        tmr_chan_regs i_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_wr      (cfg_wr[i]),
            .new_acc     (new_acc),
            .new_mode    (new_mode),
            .new_bcd     (new_bcd),
            .cnt_lat_req (cnt_lat_req[i]),
            .st_lat_req  (st_lat_req[i]),
            .data_wr     (data_wr[i]),
            .wdata       (wdata),
            .rd_sel      (rd_sel[i]),
            .live_cnt    (live_cnt[i*CNT_W +: CNT_W]),
            .live_out    (live_out[i]),
            .rd_byte     (rd_byte_a[i]),
            .ld_stb      (ld_stb[i]),
            .ld_val      (ld_val[i*CNT_W +: CNT_W]),
            .mode_q      (mode_o[i*MODE_W +: MODE_W]),
            .bcd_q       (bcd_o[i])
        );
    end

    // Read data multiplexer by address
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (addr == 2'(i)) rdata = rd_byte_a[i];
    end

    AST_ONE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_wr));                                                   // R1
    AST_NO_CFG_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != CTRL_ADDR) |=> $stable(mode_o));                   // R1
endmodule

// File: tb/test_tmr_host_if.sv
module test_tmr_host_if;
    localparam int NUM_CH = 3;
    localparam int OP_WC = 1, OP_WN = 2, OP_WL = 3, OP_RD = 4, OP_LV = 5;
    localparam int NV = 55;
    // {op, req, addr, data, expected}
    localparam logic [35:0] VEC [NV] = '{
        {4'd1, 4'd1,  4'd3, 8'h34, 16'h0000}, // R1 ch0 word mode2
        {4'd2, 4'd6,  4'd0, 8'h78, 16'h0000}, // R6 first byte held
        {4'd3, 4'd6,  4'd0, 8'h56, 16'h5678}, // R6 load
        {4'd4, 4'd7,  4'd0, 8'h00, 16'h0034}, // R7 word lo
        {4'd4, 4'd7,  4'd0, 8'h00, 16'h0012}, // R7 word hi
        {4'd1, 4'd1,  4'd3, 8'h52, 16'h0000}, // R1 ch1 lo mode1
        {4'd3, 4'd4,  4'd1, 8'h9C, 16'h009C}, // R4
        {4'd4, 4'd7,  4'd1, 8'h00, 16'h00CD}, // R7 lo only
        {4'd1, 4'd2,  4'd3, 8'hAF, 16'h0000}, // R2 ch2 hi mode7 bcd
        {4'd3, 4'd5,  4'd2, 8'h77, 16'h7700}, // R5
        {4'd4, 4'd7,  4'd2, 8'h00, 16'h005A}, // R7 hi only
        {4'd1, 4'd3,  4'd3, 8'h00, 16'h0000}, // R3 snapshot ch0
        {4'd5, 4'd0,  4'd0, 8'h00, 16'h4321},
        {4'd4, 4'd13, 4'd0, 8'h00, 16'h0034}, // R13 snap lo
        {4'd4, 4'd13, 4'd0, 8'h00, 16'h0012}, // R13 snap hi
        {4'd4, 4'd13, 4'd0, 8'h00, 16'h0021}, // R13 released, live
        {4'd4, 4'd7,  4'd0, 8'h00, 16'h0043}, // R7
        {4'd1, 4'd9,  4'd3, 8'hC2, 16'h0000}, // R9 count+status ch0
        {4'd5, 4'd0,  4'd0, 8'h00, 16'h0000},
        {4'd4, 4'd12, 4'd0, 8'h00, 16'h00B4}, // R12 status first
        {4'd4, 4'd12, 4'd0, 8'h00, 16'h0021}, // R12 then snapshot
        {4'd4, 4'd13, 4'd0, 8'h00, 16'h0043}, // R13
        {4'd4, 4'd12, 4'd0, 8'h00, 16'h0000}, // R12 then live
        {4'd4, 4'd7,  4'd0, 8'h00, 16'h0000}, // R7
        {4'd1, 4'd9,  4'd3, 8'hDC, 16'h0000}, // R9 snapshot ch1+ch2
        {4'd5, 4'd0,  4'd1, 8'h00, 16'h1111},
        {4'd5, 4'd0,  4'd2, 8'h00, 16'h2222},
        {4'd4, 4'd9,  4'd1, 8'h00, 16'h00CD}, // R9
        {4'd4, 4'd9,  4'd2, 8'h00, 16'h005A}, // R9
        {4'd4, 4'd9,  4'd2, 8'h00, 16'h0022}, // R9 released
        {4'd5, 4'd0,  4'd0, 8'h00, 16'h4321},
        {4'd1, 4'd3,  4'd3, 8'h00, 16'h0000}, // R3
        {4'd5, 4'd0,  4'd0, 8'h00, 16'h9999},
        {4'd1, 4'd11, 4'd3, 8'h00, 16'h0000}, // R11 ignored
        {4'd4, 4'd11, 4'd0, 8'h00, 16'h0021}, // R11
        {4'd4, 4'd11, 4'd0, 8'h00, 16'h0043}, // R11
        {4'd4, 4'd11, 4'd0, 8'h00, 16'h0099}, // R11
        {4'd1, 4'd10, 4'd3, 8'hE8, 16'h0000}, // R10 status ch2
        {4'd4, 4'd10, 4'd2, 8'h00, 16'h00A7}, // R10
        {4'd4, 4'd12, 4'd2, 8'h00, 16'h0022}, // R12
        {4'd2, 4'd6,  4'd0, 8'h11, 16'h0000}, // R6
        {4'd1, 4'd8,  4'd3, 8'h34, 16'h0000}, // R8
        {4'd2, 4'd8,  4'd0, 8'h22, 16'h0000}, // R8
        {4'd3, 4'd8,  4'd0, 8'h33, 16'h3322}, // R8
        {4'd5, 4'd0,  4'd0, 8'h00, 16'hBEEF},
        {4'd4, 4'd8,  4'd0, 8'h00, 16'h00EF}, // R8 read toggle reset
        {4'd1, 4'd8,  4'd3, 8'h34, 16'h0000}, // R8
        {4'd4, 4'd8,  4'd0, 8'h00, 16'h00EF}, // R8
        {4'd4, 4'd7,  4'd0, 8'h00, 16'h00BE}, // R7
        {4'd1, 4'd2,  4'd3, 8'h5C, 16'h0000}, // R2 ch1 mode6
        {4'd1, 4'd11, 4'd3, 8'hE2, 16'h0000}, // R11 status ch0
        {4'd1, 4'd1,  4'd3, 8'h14, 16'h0000}, // R1 ch0 lo
        {4'd1, 4'd11, 4'd3, 8'hE2, 16'h0000}, // R11 ignored
        {4'd4, 4'd11, 4'd0, 8'h00, 16'h00B4}, // R11
        {4'd4, 4'd12, 4'd0, 8'h00, 16'h00EF}  // R12
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NUM_CH*16-1:0] live_cnt = {16'h5A0F, 16'hABCD, 16'h1234};
    logic [NUM_CH-1:0] live_out = 3'b101;
    logic [NUM_CH-1:0] ld_stb;
    logic [NUM_CH*16-1:0] ld_val;
    logic [NUM_CH*3-1:0] mode_o;
    logic [NUM_CH-1:0] bcd_o;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_host_if #(.NUM_CH(NUM_CH)) i_tmr_host_if (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .live_out(live_out),
        .ld_stb(ld_stb), .ld_val(ld_val), .mode_o(mode_o), .bcd_o(bcd_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        check(14, 32'(mode_o), 32'h0);
        check(14, 32'(bcd_o), 32'h0);
        check(14, 32'(ld_stb), 32'h0);
        do_rd(2'd0, rb);
        check(14, 32'(rb), 32'h34);

        for (int v = 0; v < NV; v++) begin
            int op, rq, ch;
            op = int'(VEC[v][35:32]);
            rq = int'(VEC[v][31:28]);
            ch = int'(VEC[v][27:24]);
            case (op)
                OP_WC: do_wr(2'd3, VEC[v][23:16]);
                OP_WN: begin
                    do_wr(2'(ch), VEC[v][23:16]);
                    check(rq, 32'(ld_stb[ch]), 32'h0);
                end
                OP_WL: begin
                    do_wr(2'(ch), VEC[v][23:16]);
                    check(rq, 32'(ld_stb[ch]), 32'h1);
                    check(rq, 32'(ld_val[ch*16 +: 16]), 32'(VEC[v][15:0]));
                end
                OP_RD: begin
                    do_rd(2'(ch), rb);
                    check(rq, 32'(rb), 32'(VEC[v][15:0]));
                end
                OP_LV: live_cnt[ch*16 +: 16] = VEC[v][15:0];
                default: ;
            endcase
        end

        // R1 / R2 per-channel configuration after the table
        check(1, 32'(mode_o[2:0]), 32'd2);
        check(2, 32'(mode_o[5:3]), 32'd2);
        check(2, 32'(mode_o[8:6]), 32'd3);
        check(1, 32'(bcd_o), 32'b100);
        // R3 snapshot command keeps configuration
        do_wr(2'd3, 8'h80);
        check(3, 32'(mode_o), {23'd0, 3'd3, 3'd2, 3'd2});
        check(3, 32'(bcd_o), 32'b100);
        // R14 reset again
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(14, 32'(mode_o), 32'h0);
        check(14, 32'(bcd_o), 32'h0);
        do_rd(2'd2, rb); // snapshot discarded, low byte of live
        check(14, 32'(rb), 32'h22);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule